// File: doc/BRIEF.md
# Structured-Sparse Convolution Window Sequencer

This block sits in front of a four-lane SIMD multiply-accumulate unit and feeds it the weight and activation pairs of one convolution window. It takes a whole window in a single handshake. The window can be a 3x3 or a 5x5 kernel, and the block runs in one of two precisions. In dense 8-bit precision it sends one full-width pair per cycle on lane 0 and walks every tap. In sparse 4-bit precision the kernel has been pruned in a structured way to about half its taps. The block reads the keep mask, drops the pruned taps and packs the surviving pairs four to a cycle. The MAC lanes are then fully used, and each window takes the same number of cycles.

The issue stream carries a clear strobe on its first cycle and a capture strobe on its last. The accumulator uses these to start a new sum and to latch the finished one. A done pulse follows, and in that cycle the block is ready for the next window. A sparse mask that keeps more taps than the lanes can absorb in the fixed cycle budget is reported. Such a window is then issued as if every tap were pruned.

Top module: `sparse_kernel_sequencer`

## Requirements
- R1: `win_ready` is high exactly when no window is being issued. A window is accepted on a clock edge where `win_valid` and `win_ready` are both high, and its first issue cycle is the next cycle. Window inputs presented while `win_ready` is low have no effect on the window in flight.
- R2: Dense 8-bit precision (`win_prec`=0) issues one pair per cycle on lane 0 with all 8 bits. Taps are issued in raster order, where tap index = row*K + column from the top-left tap. A 3x3 kernel (`win_ksize`=0) takes 9 cycles and a 5x5 kernel (`win_ksize`=1) takes 25 cycles.
- R3: Sparse 4-bit precision (`win_prec`=1) always takes 1 issue cycle for a 3x3 kernel and 3 issue cycles for a 5x5 kernel, whatever the mask holds.
- R4: In sparse precision, the kept taps (keep bit i = 1 for tap i) are issued in raster order. The n-th survivor, counting from 0, goes to group n/4, lane n%4. Lane operands are the low 4 bits of the weight and activation, zero-extended to 8 bits.
- R5: A lane that carries no pair has its valid bit low and zero weight and activation. This applies to unused lanes in the final sparse group, to lanes 1 to 3 in dense precision, and to all lanes when idle.
- R6: In sparse precision, a mask that keeps more than 4 taps (3x3) or more than 12 taps (5x5) raises `mask_err` during all issue cycles of that window. That window issues no valid lane. `mask_err` is low in every other cycle.
- R7: `acc_clr` is high only in the first issue cycle of each window. `acc_capture` is high only in the last. Both are high together for a one-cycle window.
- R8: `done` is a single-cycle pulse in the cycle after `acc_capture`. `win_ready` is high in that cycle, so a new window can be accepted at its closing edge.
- R9: Keep-mask bits 9 to 24 are ignored for a 3x3 kernel, and the whole mask is ignored in dense precision.
- R10: After reset, no issue, clear, capture, done or error strobe is high, no lane is valid, and `win_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_valid | input | 1 | Window offered |
| win_ready | output | 1 | Block can accept a window |
| win_ksize | input | 1 | 0 = 3x3 kernel, 1 = 5x5 kernel |
| win_prec | input | 1 | 0 = dense 8-bit, 1 = sparse 4-bit |
| win_keep | input | 25 | Keep mask, bit i for raster tap i |
| win_wgt | input | 200 | Weights, tap i at bits [8i+7:8i] |
| win_act | input | 200 | Activations, tap i at bits [8i+7:8i] |
| lane_wgt | output | 32 | Lane weights, lane l at bits [8l+7:8l] |
| lane_act | output | 32 | Lane activations, lane l at bits [8l+7:8l] |
| lane_vld | output | 4 | Lane carries a pair this cycle |
| issue | output | 1 | An issue cycle of the current window |
| acc_clr | output | 1 | First issue cycle: clear accumulator |
| acc_capture | output | 1 | Last issue cycle: capture result |
| done | output | 1 | Window finished, one cycle after capture |
| mask_err | output | 1 | Current sparse window's mask exceeds the limit |

## Verification
The bench tries every 3x3 mask, with random values in the ignored high bits. A sequencer that mis-ranks survivors would then put a tap in the wrong lane. One that counts the ignored bits would report false errors or shift lanes. The 5x5 masks sit right at the 12-tap limit and one tap over it, which catches an off-by-one in the limit compare: such a design would issue a window it should reject, or blank one it should keep. The 5x5 masks also include sparse random cases whose final group is partly filled, where stale operands in unused lanes would show. Windows run back to back, accepted in the done cycle, while junk is held on the inputs during issue. This exposes a sequencer that re-samples the inputs mid-window, or one that loses the clear strobe for a one-cycle window.

// File: rtl/kseq_pkg.sv
package kseq_pkg;

  typedef enum logic {
    KSEL_SMALL = 1'b0,
    KSEL_LARGE = 1'b1
  } ksel_e;

  typedef enum logic {
    PREC_DENSE8  = 1'b0,
    PREC_SPARSE4 = 1'b1
  } prec_e;

endpackage

// File: rtl/kseq_compact.sv
module kseq_compact
  import kseq_pkg::*;
#(
  parameter int DW        = 8,
  parameter int MAXT      = 25,
  parameter int T_SMALL   = 9,
  parameter int LIM_SMALL = 4,
  parameter int LIM_LARGE = 12,
  parameter int CW        = 5
) (
  input  ksel_e                ksize,
  input  prec_e                prec,
  input  logic [MAXT-1:0]      keep,
  input  logic [MAXT*DW-1:0]   wgt,
  input  logic [MAXT*DW-1:0]   act,
  output logic [MAXT*DW-1:0]   pk_w,
  output logic [MAXT*DW-1:0]   pk_a,
  output logic [CW-1:0]        count,
  output logic                 over
);

  logic [MAXT-1:0] span;
  logic [MAXT-1:0] live;
  logic [MAXT-1:0] eff;
  int              pop;
  int              limit;

  // Taps that belong to the selected kernel, then the taps the mask keeps.
  always_comb begin
    for (int i = 0; i < MAXT; i++) begin
      span[i] = (ksize == KSEL_LARGE) || (i < T_SMALL);
    end
    live  = (prec == PREC_SPARSE4) ? (keep & span) : span;
    pop   = $countones(live);
    limit = (ksize == KSEL_LARGE) ? LIM_LARGE : LIM_SMALL;
    over  = (prec == PREC_SPARSE4) && (pop > limit);
    eff   = over ? '0 : live;
  end

  // Raster-order compaction: the k-th surviving tap lands in slot k.
  always_comb begin
    int pos;
    pos  = 0;
    pk_w = '0;
    pk_a = '0;
    for (int i = 0; i < MAXT; i++) begin
      if (eff[i]) begin
        pk_w[pos*DW +: DW] = wgt[i*DW +: DW];
        pk_a[pos*DW +: DW] = act[i*DW +: DW];
        pos = pos + 1;
      end
    end
    count = CW'(pos);
  end

endmodule

// File: rtl/kseq_ctrl.sv
module kseq_ctrl
  import kseq_pkg::*;
#(
  parameter int CW      = 5,
  parameter int T_SMALL = 9,
  parameter int T_LARGE = 25,
  parameter int G_SMALL = 1,
  parameter int G_LARGE = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          win_valid,
  input  ksel_e         ksize,
  input  prec_e         prec,
  output logic          win_ready,
  output logic          accept,
  output logic          busy,
  output logic          first,
  output logic          last,
  output logic          done,
  output logic [CW-1:0] step
);

  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic [CW-1:0] step_q, step_d;
  logic [CW-1:0] len_q, len_d, len_in;
  logic          step_en, len_en;

  always_comb begin
    unique case ({prec, ksize})
      {PREC_DENSE8,  KSEL_SMALL}: len_in = CW'(T_SMALL);
      {PREC_DENSE8,  KSEL_LARGE}: len_in = CW'(T_LARGE);
      {PREC_SPARSE4, KSEL_SMALL}: len_in = CW'(G_SMALL);
      default:                    len_in = CW'(G_LARGE);
    endcase
  end

  assign win_ready = !busy_q;
  assign accept    = win_valid && !busy_q;
  assign busy      = busy_q;
  assign first     = busy_q && (step_q == '0);
  assign last      = busy_q && (step_q == len_q - CW'(1));
  assign done      = done_q;
  assign step      = step_q;

  // Next-state logic
  always_comb begin
    busy_d  = busy_q;
    step_d  = step_q;
    len_d   = len_q;
    step_en = 1'b0;
    len_en  = 1'b0;
    done_d  = last;
    if (accept) begin
      busy_d  = 1'b1;
      step_d  = '0;
      len_d   = len_in;
      step_en = 1'b1;
      len_en  = 1'b1;
    end else if (last) begin
      busy_d  = 1'b0;
    end else if (busy_q) begin
      step_d  = step_q + CW'(1);
      step_en = 1'b1;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      step_q <= '0;
      len_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      if (step_en) step_q <= step_d;
      if (len_en)  len_q  <= len_d;
    end
  end

  a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> done);
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r1_accept_then_first: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> first);
  a_r7_clear_once: assert property (@(posedge clk) disable iff (!rst_n)
    (first && !last) |=> (busy && !first));

endmodule

// File: rtl/kseq_issue.sv
module kseq_issue
  import kseq_pkg::*;
#(
  parameter int DW    = 8,
  parameter int NW    = 4,
  parameter int LANES = 4,
  parameter int MAXT  = 25,
  parameter int CW    = 5
) (
  input  prec_e                 prec,
  input  logic                  busy,
  input  logic [CW-1:0]         step,
  input  logic [CW-1:0]         count,
  input  logic [MAXT*DW-1:0]    pk_w,
  input  logic [MAXT*DW-1:0]    pk_a,
  output logic [LANES*DW-1:0]   lane_w,
  output logic [LANES*DW-1:0]   lane_a,
  output logic [LANES-1:0]      lane_vld
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    int             idx;
    logic           v;
    logic [DW-1:0]  w, a;

    always_comb begin
      idx = (prec == PREC_SPARSE4) ? (int'(step) * LANES + l) : int'(step);
      v   = busy && (idx < int'(count)) && ((prec == PREC_SPARSE4) || (l == 0));
      w   = '0;
      a   = '0;
      if (v) begin
        w = pk_w[idx*DW +: DW];
        a = pk_a[idx*DW +: DW];
        if (prec == PREC_SPARSE4) begin
          w[DW-1:NW] = '0;
          a[DW-1:NW] = '0;
        end
      end
    end

    assign lane_w[l*DW +: DW] = w;
    assign lane_a[l*DW +: DW] = a;
    assign lane_vld[l]        = v;
  end

endmodule

// File: rtl/sparse_kernel_sequencer.sv
module sparse_kernel_sequencer
  import kseq_pkg::*;
#(
  parameter int DW      = 8,
  parameter int NW      = 4,
  parameter int LANES   = 4,
  parameter int K_SMALL = 3,
  parameter int K_LARGE = 5,
  localparam int T_SMALL   = K_SMALL * K_SMALL,
  localparam int T_LARGE   = K_LARGE * K_LARGE,
  localparam int MAXT      = T_LARGE,
  localparam int G_SMALL   = T_SMALL / (2 * LANES),
  localparam int G_LARGE   = T_LARGE / (2 * LANES),
  localparam int LIM_SMALL = G_SMALL * LANES,
  localparam int LIM_LARGE = G_LARGE * LANES,
  localparam int CW        = $clog2(MAXT + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 win_valid,
  output logic                 win_ready,
  input  logic                 win_ksize,
  input  logic                 win_prec,
  input  logic [MAXT-1:0]      win_keep,
  input  logic [MAXT*DW-1:0]   win_wgt,
  input  logic [MAXT*DW-1:0]   win_act,
  output logic [LANES*DW-1:0]  lane_wgt,
  output logic [LANES*DW-1:0]  lane_act,
  output logic [LANES-1:0]     lane_vld,
  output logic                 issue,
  output logic                 acc_clr,
  output logic                 acc_capture,
  output logic                 done,
  output logic                 mask_err
);

  ksel_e              ksize_in;
  prec_e              prec_in;
  logic [MAXT*DW-1:0] pk_w, pk_a;
  logic [CW-1:0]      count;
  logic               over;
  logic               accept, busy, first, last;
  logic [CW-1:0]      step;

  logic [MAXT*DW-1:0] pk_w_q, pk_a_q;
  logic [CW-1:0]      count_q;
  prec_e              prec_q;
  logic               over_q;

  assign ksize_in = ksel_e'(win_ksize);
  assign prec_in  = prec_e'(win_prec);

  kseq_compact #(
    .DW(DW), .MAXT(MAXT), .T_SMALL(T_SMALL),
    .LIM_SMALL(LIM_SMALL), .LIM_LARGE(LIM_LARGE), .CW(CW)
  ) u_compact (
    .ksize (ksize_in),
    .prec  (prec_in),
    .keep  (win_keep),
    .wgt   (win_wgt),
    .act   (win_act),
    .pk_w  (pk_w),
    .pk_a  (pk_a),
    .count (count),
    .over  (over)
  );

  kseq_ctrl #(
    .CW(CW), .T_SMALL(T_SMALL), .T_LARGE(T_LARGE),
    .G_SMALL(G_SMALL), .G_LARGE(G_LARGE)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .win_valid (win_valid),
    .ksize     (ksize_in),
    .prec      (prec_in),
    .win_ready (win_ready),
    .accept    (accept),
    .busy      (busy),
    .first     (first),
    .last      (last),
    .done      (done),
    .step      (step)
  );

  // Window store: control state with reset, operand store enabled on accept.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      prec_q  <= PREC_DENSE8;
      over_q  <= 1'b0;
    end else if (accept) begin
      count_q <= count;
      prec_q  <= prec_in;
      over_q  <= over;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      pk_w_q <= pk_w;
      pk_a_q <= pk_a;
    end
  end

  kseq_issue #(
    .DW(DW), .NW(NW), .LANES(LANES), .MAXT(MAXT), .CW(CW)
  ) u_issue (
    .prec     (prec_q),
    .busy     (busy),
    .step     (step),
    .count    (count_q),
    .pk_w     (pk_w_q),
    .pk_a     (pk_a_q),
    .lane_w   (lane_wgt),
    .lane_a   (lane_act),
    .lane_vld (lane_vld)
  );

  assign issue       = busy;
  assign acc_clr     = first;
  assign acc_capture = last;
  assign mask_err    = busy && over_q;

  a_r5_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |-> (lane_vld == '0));
  a_r6_err_blanks: assert property (@(posedge clk) disable iff (!rst_n)
    mask_err |-> (lane_vld == '0));
  a_r2_dense_lane0: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && prec_q == PREC_DENSE8) |-> (lane_vld == LANES'(1)));
  a_r4_prefix_fill: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> (((lane_vld + LANES'(1)) & lane_vld) == '0));
  a_r8_ready_in_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> win_ready);

  for (genvar l = 0; l < LANES; l++) begin : g_chk
    a_r5_zero_operands: assert property (@(posedge clk) disable iff (!rst_n)
      !lane_vld[l] |-> (lane_wgt[l*DW +: DW] == '0 && lane_act[l*DW +: DW] == '0));
    a_r4_nibble_only: assert property (@(posedge clk) disable iff (!rst_n)
      (issue && prec_q == PREC_SPARSE4) |->
        (lane_wgt[l*DW+NW +: DW-NW] == '0 && lane_act[l*DW+NW +: DW-NW] == '0));
  end

endmodule

// File: tb/sparse_kernel_sequencer_test.sv
module sparse_kernel_sequencer_test;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         win_valid;
  logic         win_ready;
  logic         win_ksize;
  logic         win_prec;
  logic [24:0]  win_keep;
  logic [199:0] win_wgt;
  logic [199:0] win_act;
  logic [31:0]  lane_wgt;
  logic [31:0]  lane_act;
  logic [3:0]   lane_vld;
  logic         issue, acc_clr, acc_capture, done, mask_err;

  int nchecks = 0;
  int nerr    = 0;
  logic [31:0] rng = 32'h1234_5678;

  always #10 clk = ~clk;

  sparse_kernel_sequencer uut (
    .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .win_ready(win_ready),
    .win_ksize(win_ksize), .win_prec(win_prec), .win_keep(win_keep),
    .win_wgt(win_wgt), .win_act(win_act), .lane_wgt(lane_wgt),
    .lane_act(lane_act), .lane_vld(lane_vld), .issue(issue),
    .acc_clr(acc_clr), .acc_capture(acc_capture), .done(done),
    .mask_err(mask_err)
  );

  function automatic logic [7:0] wv(input int i, input int seed);
    return 8'(i * 37 + seed * 13 + 1);
  endfunction

  function automatic logic [7:0] av(input int i, input int seed);
    return 8'(i * 91 + seed * 29 + 7);
  endfunction

  function automatic logic [31:0] nextrng(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] got,
                     input logic [63:0] exp);
    nchecks++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  // Called at a falling edge. Offers one window, follows its issue cycles,
  // and returns at the falling edge of the done cycle.
  task automatic run_window(input bit ks, input bit pr, input logic [24:0] keep,
                            input int seed, input bit junk, input string tag);
    int   list[25];
    int   n, taps, grps, len;
    bit   over;
    n    = 0;
    taps = ks ? 25 : 9;
    grps = ks ? 3 : 1;
    for (int i = 0; i < 25; i++) list[i] = 0;
    if (pr) begin
      for (int i = 0; i < taps; i++) if (keep[i]) begin list[n] = i; n++; end
    end
    over = pr && (n > grps * 4);
    if (over) n = 0;
    len = pr ? grps : taps;

    win_valid = 1'b1;
    win_ksize = ks;
    win_prec  = pr;
    win_keep  = keep;
    for (int i = 0; i < 25; i++) begin
      win_wgt[i*8 +: 8] = wv(i, seed);
      win_act[i*8 +: 8] = av(i, seed);
    end
    chk(win_ready === 1'b1, "R1 ready before accept", 64'(win_ready), 64'd1);
    @(posedge clk);
    @(negedge clk);
    if (junk) begin
      win_valid = 1'b1;
      win_ksize = ~ks;
      win_prec  = ~pr;
      win_keep  = ~keep;
      win_wgt   = ~win_wgt;
      win_act   = {win_act[198:0], win_act[199]};
    end else begin
      win_valid = 1'b0;
    end

    for (int c = 0; c < len; c++) begin
      logic [5:0] gc, ec;
      gc = {issue, acc_clr, acc_capture, done, win_ready, mask_err};
      ec = {1'b1, (c == 0), (c == len - 1), 1'b0, 1'b0, over};
      chk(gc === ec, {"R3 R7 R6 R1 ", tag}, 64'(gc), 64'(ec));
      for (int l = 0; l < 4; l++) begin
        logic [16:0] g, e;
        int idx;
        bit v;
        logic [7:0] ew, ea;
        if (pr) begin
          idx = c * 4 + l;
          v   = idx < n;
          ew  = v ? (wv(list[idx], seed) & 8'h0F) : 8'h00;
          ea  = v ? (av(list[idx], seed) & 8'h0F) : 8'h00;
        end else begin
          v   = (l == 0);
          ew  = v ? wv(c, seed) : 8'h00;
          ea  = v ? av(c, seed) : 8'h00;
        end
        g = {lane_vld[l], lane_wgt[l*8 +: 8], lane_act[l*8 +: 8]};
        e = {v, ew, ea};
        chk(g === e, pr ? (v ? {"R4 ", tag} : {"R5 ", tag}) : {"R2 R5 ", tag},
            64'(g), 64'(e));
      end
      @(negedge clk);
    end

    chk({issue, done, win_ready, acc_capture} === 4'b0110, {"R8 ", tag},
        64'({issue, done, win_ready, acc_capture}), 64'h6);
  endtask

  initial begin
    #(20 * 200000);
    nchecks++;
    nerr++;
    $display("FAIL R1 watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    win_valid = 1'b0;
    win_ksize = 1'b0;
    win_prec  = 1'b0;
    win_keep  = '0;
    win_wgt   = '0;
    win_act   = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk({issue, acc_clr, acc_capture, done, mask_err, lane_vld, win_ready} === 10'b0000000001,
        "R10 reset outputs", 64'({issue, acc_clr, acc_capture, done, mask_err, lane_vld, win_ready}),
        64'h1);
    rst_n = 1'b1;
    @(negedge clk);
    chk({issue, done, win_ready} === 3'b001, "R10 after release",
        64'({issue, done, win_ready}), 64'h1);

    // R2 R9: dense windows, mask contents must not matter
    for (int s = 0; s < 4; s++) begin
      rng = nextrng(rng);
      run_window(1'b0, 1'b0, rng[24:0], s, 1'b1, "R9 dense3");
    end
    for (int s = 0; s < 4; s++) begin
      rng = nextrng(rng);
      run_window(1'b1, 1'b0, rng[24:0], 10 + s, 1'b1, "R9 dense5");
    end

    // R4 R6 R9: every 3x3 mask, garbage in the ignored upper bits
    for (int m = 0; m < 512; m++) begin
      logic [15:0] hi;
      hi = 16'(m * 40503 + 7);
      run_window(1'b0, 1'b1, {hi, 9'(m)}, m, m[0], "R9 sparse3");
    end

    // R6: 5x5 masks at and around the limit
    run_window(1'b1, 1'b1, 25'h0000000, 1, 1'b1, "R6 none");
    run_window(1'b1, 1'b1, 25'h0000FFF, 2, 1'b1, "R6 twelve low");
    run_window(1'b1, 1'b1, 25'h0001FFF, 3, 1'b1, "R6 thirteen");
    run_window(1'b1, 1'b1, 25'h1FFE000, 4, 1'b1, "R6 twelve high");
    run_window(1'b1, 1'b1, 25'h1555555, 5, 1'b1, "R6 even taps");
    run_window(1'b1, 1'b1, 25'h0AAAAAA, 6, 1'b1, "R6 odd taps");
    run_window(1'b1, 1'b1, 25'h1FFFFFF, 7, 1'b1, "R6 all");

    // R4 R5: random 5x5 masks, half of them thinned
    for (int k = 0; k < 300; k++) begin
      logic [24:0] mk;
      rng = nextrng(rng);
      mk  = rng[24:0];
      if (k[0]) begin
        rng = nextrng(rng);
        mk  = mk & rng[24:0];
      end
      run_window(1'b1, 1'b1, mk, 100 + k, k[1], "R4 sparse5");
    end

    // Final dense window with inputs dropped during issue
    run_window(1'b0, 1'b0, 25'h0, 77, 1'b0, "R2 final");
    @(negedge clk);
    chk({done, issue, win_ready} === 3'b001, "R8 done is one cycle",
        64'({done, issue, win_ready}), 64'h1);

    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end

endmodule